// File: doc/BRIEF.md
# Two-Region Key-Sequence Write Unlock

This block keeps two nonvolatile memory regions write-protected until software proves intent. One region holds program code. The other holds data and option settings. Each region has its own key register on a byte-wide register port. Two fixed key bytes must arrive there in a fixed order. When they do, that region's unlock flag in a shared status register goes high, and a write-enable qualifier toward the flash controller is asserted.

Software locks a region again by writing zero to its flag. It cannot set a flag directly. The program region reacts harshly to a bad key: it bars itself until reset. The data region simply returns to waiting for a fresh sequence. Option-area writes need a separate enable bit in a control register in addition to the data unlock.

Top module: `mem_write_unlock`

## Requirements
- R1: After reset, both regions are locked, the program lockout is clear, the option enable is 0, all three qualifiers are low, and the status and control registers read 0x00.
- R2: Writing 0x56 and then 0xAE to the program key register (address 2) sets status bit 1 and `prog_wr_ok` in the cycle after the second write.
- R3: Writing 0xAE and then 0x56 to the data key register (address 3) sets status bit 3 and `data_wr_ok` in the cycle after the second write.
- R4: A wrong first or second byte on the program key register sets the lockout flag (status bit 6). After that, every program key write is ignored until reset, including the correct sequence.
- R5: A wrong first or second byte on the data key register returns it to waiting, without a lockout. A correct sequence written straight afterwards unlocks the data region.
- R6: Writing the status register (address 4) with bit 1 or bit 3 at 0 relocks the matching unlocked region. Writing 1 to a flag of a locked region leaves it locked.
- R7: A key write to a region that is already unlocked is ignored. The region stays unlocked and no lockout is raised.
- R8: Control register (address 0) bit 7 is the option enable and reads back as written. `opt_wr_ok` is high only while that bit is 1 and the data region is unlocked.
- R9: Key writes to one region's key register never change the other region's unlock or lockout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_raddr` |
| prog_wr_ok | output | 1 | Program region may be written |
| data_wr_ok | output | 1 | Data region may be written |
| opt_wr_ok | output | 1 | Option area may be written |

## Verification
The bench uses the default parameters: an 8-bit data port, a 4-bit address, and the key bytes 0x56/0xAE for the program region and 0xAE/0x56 for the data region. Because the two sequences mirror each other, feeding one region's sequence into the other region's key register is a real test. It bars the program region, but it only half-advances the data region. The bench uses this to show that the regions are separated and that the two wrong-key policies differ. Each scenario that depends on lockout starts from its own reset, so a barred program region can be observed cleanly alongside the correct sequence.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

  localparam int KEY_W = 8;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_BARRED = 2'd3
  } key_state_t;

  // One step of a key sequence; err_to is where a mismatch lands.
  function automatic key_state_t key_step(
    input key_state_t     cur,
    input logic           key_we,
    input logic [KEY_W-1:0] kbyte,
    input logic           relock,
    input logic [KEY_W-1:0] k_first,
    input logic [KEY_W-1:0] k_second,
    input key_state_t     err_to
  );
    key_state_t nxt;
    nxt = cur;
    case (cur)
      KS_IDLE:   if (key_we) nxt = (kbyte == k_first)  ? KS_HALF : err_to;
      KS_HALF:   if (key_we) nxt = (kbyte == k_second) ? KS_OPEN : err_to;
      KS_OPEN:   if (relock) nxt = KS_IDLE;
      KS_BARRED: nxt = KS_BARRED;
      default:   nxt = KS_IDLE;
    endcase
    return nxt;
  endfunction

  // A status write relocks a flag when that flag's bit is written as zero.
  function automatic logic flag_cleared(input logic [KEY_W-1:0] word, input int pos);
    return (word[pos] == 1'b0);
  endfunction

endpackage

// File: rtl/mwu_key_seq.sv
module mwu_key_seq
  import mwu_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_FIRST    = 8'h56,
  parameter logic [KEY_W-1:0] KEY_SECOND   = 8'hAE,
  parameter bit               BAR_ON_ERROR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_byte,
  input  logic             relock_req,
  output logic             unlocked,
  output logic             barred
);

  localparam key_state_t ERR_TO = BAR_ON_ERROR ? KS_BARRED : KS_IDLE;

  key_state_t state, state_nxt;

  always_comb
    state_nxt = key_step(state, key_we, key_byte, relock_req, KEY_FIRST, KEY_SECOND, ERR_TO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= KS_IDLE;
    else        state <= state_nxt;
  end

  assign unlocked = (state == KS_OPEN);
  assign barred   = (state == KS_BARRED);

  // R2 / R3: the region opens only right after the second key byte.
  assert_open_by_second_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_we && key_byte == KEY_SECOND));

  // R4: once barred, the region stays barred until reset.
  assert_lockout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    barred |=> barred);

  // R7: key writes do not disturb an unlocked region.
  assert_open_ignores_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_we && !relock_req) |=> unlocked);

  // R5: a region without lockout policy never reaches the barred state.
  assert_retry_no_bar_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!BAR_ON_ERROR && key_we) |=> !barred);

endmodule

// File: rtl/mwu_regs.sv
module mwu_regs
  import mwu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd0,
  parameter logic [ADDR_W-1:0] KEYP_ADDR = 4'd2,
  parameter logic [ADDR_W-1:0] KEYD_ADDR = 4'd3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'd4,
  parameter int PROG_FLAG_BIT = 1,
  parameter int DATA_FLAG_BIT = 3,
  parameter int BAR_FLAG_BIT  = 6,
  parameter int OPT_EN_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              prog_open,
  input  logic              data_open,
  input  logic              prog_barred,
  output logic              prog_key_we,
  output logic              data_key_we,
  output logic [KEY_W-1:0]  key_byte,
  output logic              prog_relock,
  output logic              data_relock,
  output logic              opt_en,
  output logic [DATA_W-1:0] rd_data
);

  logic stat_we, ctrl_we;

  assign stat_we     = wr_en && (wr_addr == STAT_ADDR);
  assign ctrl_we     = wr_en && (wr_addr == CTRL_ADDR);
  assign prog_key_we = wr_en && (wr_addr == KEYP_ADDR);
  assign data_key_we = wr_en && (wr_addr == KEYD_ADDR);
  assign key_byte    = wr_data[KEY_W-1:0];

  assign prog_relock = stat_we && flag_cleared(wr_data[KEY_W-1:0], PROG_FLAG_BIT);
  assign data_relock = stat_we && flag_cleared(wr_data[KEY_W-1:0], DATA_FLAG_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opt_en <= 1'b0;
    else if (ctrl_we) opt_en <= wr_data[OPT_EN_BIT];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) begin
      rd_data[PROG_FLAG_BIT] = prog_open;
      rd_data[DATA_FLAG_BIT] = data_open;
      rd_data[BAR_FLAG_BIT]  = prog_barred;
    end else if (rd_addr == CTRL_ADDR) begin
      rd_data[OPT_EN_BIT] = opt_en;
    end
  end

  // R8: the option enable follows the last control write.
  assert_opt_en_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (opt_en == $past(wr_data[OPT_EN_BIT])));

endmodule

// File: rtl/mem_write_unlock.sv
module mem_write_unlock
  import mwu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [KEY_W-1:0] PROG_KEY_A = 8'h56,
  parameter logic [KEY_W-1:0] PROG_KEY_B = 8'hAE,
  parameter logic [KEY_W-1:0] DATA_KEY_A = 8'hAE,
  parameter logic [KEY_W-1:0] DATA_KEY_B = 8'h56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              prog_wr_ok,
  output logic              data_wr_ok,
  output logic              opt_wr_ok
);

  logic prog_key_we, data_key_we, prog_relock, data_relock, opt_en;
  logic prog_open, data_open, prog_barred, data_barred;
  logic [KEY_W-1:0] key_byte;

  mwu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata), .rd_addr(reg_raddr),
    .prog_open(prog_open), .data_open(data_open), .prog_barred(prog_barred),
    .prog_key_we(prog_key_we), .data_key_we(data_key_we), .key_byte(key_byte),
    .prog_relock(prog_relock), .data_relock(data_relock),
    .opt_en(opt_en), .rd_data(reg_rdata)
  );

  mwu_key_seq #(.KEY_FIRST(PROG_KEY_A), .KEY_SECOND(PROG_KEY_B), .BAR_ON_ERROR(1'b1)) u_prog (
    .clk(clk), .rst_n(rst_n), .key_we(prog_key_we), .key_byte(key_byte),
    .relock_req(prog_relock), .unlocked(prog_open), .barred(prog_barred)
  );

  mwu_key_seq #(.KEY_FIRST(DATA_KEY_A), .KEY_SECOND(DATA_KEY_B), .BAR_ON_ERROR(1'b0)) u_data (
    .clk(clk), .rst_n(rst_n), .key_we(data_key_we), .key_byte(key_byte),
    .relock_req(data_relock), .unlocked(data_open), .barred(data_barred)
  );

  assign prog_wr_ok = prog_open;
  assign data_wr_ok = data_open && !data_barred;
  assign opt_wr_ok  = data_wr_ok && opt_en;

  // R8: option writes are never qualified without the data unlock.
  assert_opt_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr_ok |-> data_wr_ok);

  // R6: a zero written to the program flag relocks an open program region.
  assert_prog_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_relock && prog_open) |=> !prog_wr_ok);

  // R9: data key writes never change the program region state.
  assert_data_key_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_key_we && !prog_relock) |=> $stable(prog_wr_ok));

endmodule

// File: tb/mem_write_unlock_test.sv
`timescale 1ns/1ps
module mem_write_unlock_test;

  localparam logic [3:0] A_CTRL = 4'd0, A_KEYP = 4'd2, A_KEYD = 4'd3, A_STAT = 4'd4;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_waddr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic prog_wr_ok, data_wr_ok, opt_wr_ok;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  mem_write_unlock uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .prog_wr_ok(prog_wr_ok), .data_wr_ok(data_wr_ok), .opt_wr_ok(opt_wr_ok)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [7:0] stat_exp(input logic p, input logic d, input logic bar);
    return {1'b0, bar, 2'b00, d, 1'b0, p, 1'b0};
  endfunction

  task automatic t_reset_R1();
    logic [7:0] v;
    do_reset();
    rd(A_STAT, v); check("R1 status", v, 8'h00);
    rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    check("R1 outputs", {5'b0, prog_wr_ok, data_wr_ok, opt_wr_ok}, 8'h00);
  endtask

  task automatic t_prog_unlock_R2();
    logic [7:0] v;
    do_reset();
    wr(A_KEYP, 8'h56);
    check("R2 half", {7'b0, prog_wr_ok}, 8'h00);
    wr(A_KEYP, 8'hAE);
    rd(A_STAT, v); check("R2 status", v, stat_exp(1, 0, 0));
    check("R2 prog_wr_ok", {7'b0, prog_wr_ok}, 8'h01);
  endtask

  task automatic t_data_unlock_R3();
    logic [7:0] v;
    do_reset();
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56);
    rd(A_STAT, v); check("R3 status", v, stat_exp(0, 1, 0));
    check("R3 data_wr_ok", {7'b0, data_wr_ok}, 8'h01);
  endtask

  task automatic t_prog_bad_R4();
    logic [7:0] v;
    do_reset();
    wr(A_KEYP, 8'h11);
    rd(A_STAT, v); check("R4 bad first lockout", v, stat_exp(0, 0, 1));
    wr(A_KEYP, 8'h56); wr(A_KEYP, 8'hAE);
    rd(A_STAT, v); check("R4 correct keys ignored", v, stat_exp(0, 0, 1));
    check("R4 prog_wr_ok low", {7'b0, prog_wr_ok}, 8'h00);
    do_reset();
    wr(A_KEYP, 8'h56); wr(A_KEYP, 8'h56);
    rd(A_STAT, v); check("R4 bad second lockout", v, stat_exp(0, 0, 1));
    do_reset();
    rd(A_STAT, v); check("R4 reset clears lockout", v, 8'h00);
  endtask

  task automatic t_data_retry_R5();
    logic [7:0] v;
    do_reset();
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h12);
    rd(A_STAT, v); check("R5 no lockout", v, 8'h00);
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56);
    rd(A_STAT, v); check("R5 retry unlocks", v, stat_exp(0, 1, 0));
    do_reset();
    wr(A_KEYD, 8'h00); wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56);
    check("R5 retry after bad first", {7'b0, data_wr_ok}, 8'h01);
  endtask

  task automatic t_relock_R6();
    logic [7:0] v;
    do_reset();
    wr(A_STAT, 8'h0A);
    rd(A_STAT, v); check("R6 set-one ignored", v, 8'h00);
    check("R6 outputs stay low", {6'b0, prog_wr_ok, data_wr_ok}, 8'h00);
    wr(A_KEYP, 8'h56); wr(A_KEYP, 8'hAE);
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56);
    wr(A_STAT, 8'h08);
    rd(A_STAT, v); check("R6 prog relocked, data kept", v, stat_exp(0, 1, 0));
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R6 both relocked", v, 8'h00);
    check("R6 data_wr_ok low", {7'b0, data_wr_ok}, 8'h00);
  endtask

  task automatic t_key_while_open_R7();
    logic [7:0] v;
    do_reset();
    wr(A_KEYP, 8'h56); wr(A_KEYP, 8'hAE);
    wr(A_KEYP, 8'h00);
    rd(A_STAT, v); check("R7 prog stays open", v, stat_exp(1, 0, 0));
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56); wr(A_KEYD, 8'h99);
    rd(A_STAT, v); check("R7 data stays open", v, stat_exp(1, 1, 0));
  endtask

  task automatic t_option_R8();
    logic [7:0] v;
    do_reset();
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, v); check("R8 ctrl readback", v, 8'h80);
    check("R8 opt needs data", {7'b0, opt_wr_ok}, 8'h00);
    wr(A_KEYD, 8'hAE); wr(A_KEYD, 8'h56);
    check("R8 opt enabled", {7'b0, opt_wr_ok}, 8'h01);
    wr(A_CTRL, 8'h00);
    check("R8 opt cleared", {6'b0, data_wr_ok, opt_wr_ok}, 8'h02);
  endtask

  task automatic t_cross_R9();
    logic [7:0] v;
    do_reset();
    wr(A_KEYD, 8'h56); wr(A_KEYD, 8'hAE);
    rd(A_STAT, v); check("R9 prog order on data reg", v, 8'h00);
    wr(A_KEYP, 8'hAE);
    rd(A_STAT, v); check("R9 prog barred only", v, stat_exp(0, 0, 1));
    wr(A_KEYD, 8'h56);
    rd(A_STAT, v); check("R9 data unaffected by prog bar", v, stat_exp(0, 1, 1));
  endtask

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_prog_unlock_R2();
    t_data_unlock_R3();
    t_prog_bad_R4();
    t_data_retry_R5();
    t_relock_R6();
    t_key_while_open_R7();
    t_option_R8();
    t_cross_R9();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule